// File: doc/BRIEF.md
# Banked ROM Disk Window

This block lets a host reach a large ROM image through a 64 KB window at a fixed place in its 20-bit memory map. One 8-bit control register holds both an enable flag and a bank number, so a single I/O write picks the bank and opens the window together. While the window is open and a ROM is fitted, the block claims host memory reads that fall inside it. It turns each one into a ROM byte address and returns the byte one cycle later.

The bank number wraps at the ROM size, so the upper bank bits are ignored when the ROM is smaller than the bank field can reach. Whether a ROM is fitted is latched from an input pin during reset. With no ROM, the window never claims a cycle, and every read the block serves returns all ones. The control register reads back exactly the value last written. Writes into the window and loading the ROM are handled elsewhere.

Top module: `romwin_top`

## Requirements
- R1: After reset the control register reads 0x00 and the window claims no address.
- R2: A control-port read returns, one cycle after the read strobe, the full 8-bit value last written to the control port, unchanged.
- R3: `mem_claim_o` is high only when control bit 7 is set, a ROM was latched as fitted, and the memory address lies in WIN_BASE to WIN_BASE+0xFFFF (default 0xA0000 to 0xAFFFF).
- R4: During a claimed read, `rom_addr_o` equals bank × 0x10000 plus the low 16 bits of the memory address.
- R5: The bank (control bits 6:0) wraps modulo the ROM size: only its low ROM_AW−16 bits reach `rom_addr_o`.
- R6: One cycle after a memory read strobe, `mem_rvalid_o` is high and `mem_rdata_o` holds the ROM byte for that address if the read was claimed.
- R7: When no ROM is fitted, the window is never claimed even with bit 7 set, and reads return 0xFF.
- R8: The ROM-fitted input is sampled only during reset; changing it afterwards has no effect on claiming.
- R9: A control write takes effect for a memory read in the very next cycle.
- R10: Any memory read that is not claimed returns 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rom_fitted_i | input | 1 | High when a ROM image is present; latched during reset |
| io_wr_i | input | 1 | Control-port write strobe |
| io_rd_i | input | 1 | Control-port read strobe |
| io_wdata_i | input | 8 | Control-port write data (bit 7 enable, bits 6:0 bank) |
| io_rdata_o | output | 8 | Registered control-port read data |
| mem_rd_i | input | 1 | Host memory read strobe |
| mem_addr_i | input | ADDR_W | Host memory address |
| mem_claim_o | output | 1 | Window claims the current memory cycle |
| mem_rvalid_o | output | 1 | Read data valid, one cycle after the strobe |
| mem_rdata_o | output | 8 | Registered read data |
| rom_addr_o | output | ROM_AW | ROM byte address |
| rom_rdata_i | input | 8 | ROM byte at `rom_addr_o` |

## Verification
The bench builds the block with ROM_AW = 18, which gives a 256 KB image with four banks, and keeps the default window base. With that size, bank numbers 5 and 127 fall beyond the image and must fold back onto banks 1 and 3, so the wrap rule can be checked without a large model. A second reset with the fitted pin low covers the no-ROM case. The pin is also toggled after each reset to show that the latched value is the one in force.

// File: rtl/romwin_pkg.sv
package romwin_pkg;
  localparam int CTRL_W = 8;
  localparam int BANK_FIELD_W = 7;

  typedef struct packed {
    logic                    en;
    logic [BANK_FIELD_W-1:0] bank;
  } ctrl_t;
endpackage

// File: rtl/romwin_ctrl.sv
module romwin_ctrl
  import romwin_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        rom_fitted_i,
  input  logic        io_wr_i,
  input  logic        io_rd_i,
  input  logic [7:0]  io_wdata_i,
  output logic [7:0]  io_rdata_o,
  output ctrl_t       ctrl_o,
  output logic        present_o
);
  ctrl_t ctrl_q;
  logic  present_q;

  // Control register and presence latch
  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q    <= '0;
      present_q <= rom_fitted_i;
    end else if (io_wr_i) begin
      ctrl_q <= ctrl_t'(io_wdata_i);
    end
  end

  // Registered readback
  always_ff @(posedge clk) begin
    if (rst)
      io_rdata_o <= '0;
    else if (io_rd_i)
      io_rdata_o <= ctrl_q;
  end

  assign ctrl_o    = ctrl_q;
  assign present_o = present_q;
endmodule

// File: rtl/romwin_decode.sv
module romwin_decode
  import romwin_pkg::*;
#(
  parameter int              ADDR_W   = 20,
  parameter int              ROM_AW   = 19,
  parameter int              WIN_AW   = 16,
  parameter logic [ADDR_W-1:0] WIN_BASE = 20'hA0000
) (
  input  ctrl_t              ctrl_i,
  input  logic               present_i,
  input  logic [ADDR_W-1:0]  mem_addr_i,
  output logic               claim_o,
  output logic [ROM_AW-1:0]  rom_addr_o
);
  localparam int SEL_W = ROM_AW - WIN_AW;
  localparam int TAG_W = ADDR_W - WIN_AW;

  logic hit;
  assign hit     = (mem_addr_i[ADDR_W-1:WIN_AW] == WIN_BASE[ADDR_W-1:WIN_AW]);
  assign claim_o = ctrl_i.en & present_i & hit;

  generate
    if (SEL_W == 0) begin : g_single_bank
      assign rom_addr_o = mem_addr_i[WIN_AW-1:0];
      logic unused_bank;
      assign unused_bank = ^ctrl_i.bank;
    end else if (SEL_W >= BANK_FIELD_W) begin : g_full_bank
      assign rom_addr_o = {{(SEL_W-BANK_FIELD_W){1'b0}}, ctrl_i.bank,
                           mem_addr_i[WIN_AW-1:0]};
    end else begin : g_wrap_bank
      // Upper bank bits fall off: bank wraps modulo the image size
      assign rom_addr_o = {ctrl_i.bank[SEL_W-1:0], mem_addr_i[WIN_AW-1:0]};
      logic unused_hi;
      assign unused_hi = ^ctrl_i.bank[BANK_FIELD_W-1:SEL_W];
    end
  endgenerate

  logic unused_tag;
  assign unused_tag = ^TAG_W;
endmodule

// File: rtl/romwin_rdata.sv
module romwin_rdata #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_i,
  input  logic              claim_i,
  input  logic [DATA_W-1:0] rom_data_i,
  output logic              rvalid_o,
  output logic [DATA_W-1:0] rdata_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      rvalid_o <= 1'b0;
      rdata_o  <= '1;
    end else begin
      rvalid_o <= rd_i;
      if (rd_i)
        rdata_o <= claim_i ? rom_data_i : '1;
    end
  end
endmodule

// File: rtl/romwin_top.sv
module romwin_top
  import romwin_pkg::*;
#(
  parameter int                ADDR_W   = 20,
  parameter int                ROM_AW   = 19,
  parameter int                WIN_AW   = 16,
  parameter logic [ADDR_W-1:0] WIN_BASE = 20'hA0000
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               rom_fitted_i,
  input  logic               io_wr_i,
  input  logic               io_rd_i,
  input  logic [7:0]         io_wdata_i,
  output logic [7:0]         io_rdata_o,
  input  logic               mem_rd_i,
  input  logic [ADDR_W-1:0]  mem_addr_i,
  output logic               mem_claim_o,
  output logic               mem_rvalid_o,
  output logic [7:0]         mem_rdata_o,
  output logic [ROM_AW-1:0]  rom_addr_o,
  input  logic [7:0]         rom_rdata_i
);
  ctrl_t ctrl;
  logic  present;

  romwin_ctrl u_ctrl (
    .clk          (clk),
    .rst          (rst),
    .rom_fitted_i (rom_fitted_i),
    .io_wr_i      (io_wr_i),
    .io_rd_i      (io_rd_i),
    .io_wdata_i   (io_wdata_i),
    .io_rdata_o   (io_rdata_o),
    .ctrl_o       (ctrl),
    .present_o    (present)
  );

  romwin_decode #(
    .ADDR_W   (ADDR_W),
    .ROM_AW   (ROM_AW),
    .WIN_AW   (WIN_AW),
    .WIN_BASE (WIN_BASE)
  ) u_decode (
    .ctrl_i     (ctrl),
    .present_i  (present),
    .mem_addr_i (mem_addr_i),
    .claim_o    (mem_claim_o),
    .rom_addr_o (rom_addr_o)
  );

  romwin_rdata #(.DATA_W(8)) u_rdata (
    .clk        (clk),
    .rst        (rst),
    .rd_i       (mem_rd_i),
    .claim_i    (mem_claim_o),
    .rom_data_i (rom_rdata_i),
    .rvalid_o   (mem_rvalid_o),
    .rdata_o    (mem_rdata_o)
  );
endmodule

// File: rtl/romwin_checker.sv
module romwin_checker #(
  parameter int                ADDR_W   = 20,
  parameter int                WIN_AW   = 16,
  parameter logic [ADDR_W-1:0] WIN_BASE = 20'hA0000
) (
  input logic              clk,
  input logic              rst,
  input logic              io_wr_i,
  input logic              io_rd_i,
  input logic [7:0]        io_wdata_i,
  input logic [7:0]        io_rdata_o,
  input logic              mem_rd_i,
  input logic [ADDR_W-1:0] mem_addr_i,
  input logic              mem_claim_o,
  input logic              mem_rvalid_o,
  input logic [7:0]        mem_rdata_o,
  input logic              present,
  input logic [7:0]        ctrl
);
  p_claim_needs_enable_r3: assert property (@(posedge clk) disable iff (rst)
    mem_claim_o |-> (ctrl[7] && present));

  p_claim_in_window_r3: assert property (@(posedge clk) disable iff (rst)
    mem_claim_o |-> (mem_addr_i[ADDR_W-1:WIN_AW] == WIN_BASE[ADDR_W-1:WIN_AW]));

  p_no_rom_no_claim_r7: assert property (@(posedge clk) disable iff (rst)
    !present |-> !mem_claim_o);

  p_rvalid_follows_r6: assert property (@(posedge clk) disable iff (rst)
    mem_rd_i |=> mem_rvalid_o);

  p_unclaimed_ones_r10: assert property (@(posedge clk) disable iff (rst)
    (mem_rd_i && !mem_claim_o) |=> (mem_rdata_o == 8'hFF));

  p_readback_r2: assert property (@(posedge clk) disable iff (rst)
    (io_wr_i && !io_rd_i) ##1 (io_rd_i && !io_wr_i) |=> (io_rdata_o == $past(io_wdata_i, 2)));

  p_present_held_r8: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> $stable(present));
endmodule

bind romwin_top romwin_checker #(
  .ADDR_W   (ADDR_W),
  .WIN_AW   (WIN_AW),
  .WIN_BASE (WIN_BASE)
) u_checker (
  .clk          (clk),
  .rst          (rst),
  .io_wr_i      (io_wr_i),
  .io_rd_i      (io_rd_i),
  .io_wdata_i   (io_wdata_i),
  .io_rdata_o   (io_rdata_o),
  .mem_rd_i     (mem_rd_i),
  .mem_addr_i   (mem_addr_i),
  .mem_claim_o  (mem_claim_o),
  .mem_rvalid_o (mem_rvalid_o),
  .mem_rdata_o  (mem_rdata_o),
  .present      (present),
  .ctrl         (ctrl)
);

// File: tb/romwin_top_bench.sv
module romwin_top_bench;
  localparam int ADDR_W = 20;
  localparam int ROM_AW = 18;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              rom_fitted_i = 1'b1;
  logic              io_wr_i = 1'b0;
  logic              io_rd_i = 1'b0;
  logic [7:0]        io_wdata_i = '0;
  logic [7:0]        io_rdata_o;
  logic              mem_rd_i = 1'b0;
  logic [ADDR_W-1:0] mem_addr_i = '0;
  logic              mem_claim_o;
  logic              mem_rvalid_o;
  logic [7:0]        mem_rdata_o;
  logic [ROM_AW-1:0] rom_addr_o;
  logic [7:0]        rom_rdata_i;

  int checks = 0;
  int errors = 0;

  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #5 clk = ~clk;

  function automatic logic [7:0] rom_byte(input logic [ROM_AW-1:0] a);
    return a[7:0] ^ {a[11:8], a[15:12]} ^ (8'h51 * {6'd0, a[17:16]});
  endfunction

  assign rom_rdata_i = rom_byte(rom_addr_o);

  romwin_top #(.ADDR_W(ADDR_W), .ROM_AW(ROM_AW)) u_romwin_top (
    .clk          (clk),
    .rst          (rst),
    .rom_fitted_i (rom_fitted_i),
    .io_wr_i      (io_wr_i),
    .io_rd_i      (io_rd_i),
    .io_wdata_i   (io_wdata_i),
    .io_rdata_o   (io_rdata_o),
    .mem_rd_i     (mem_rd_i),
    .mem_addr_i   (mem_addr_i),
    .mem_claim_o  (mem_claim_o),
    .mem_rvalid_o (mem_rvalid_o),
    .mem_rdata_o  (mem_rdata_o),
    .rom_addr_o   (rom_addr_o),
    .rom_rdata_i  (rom_rdata_i)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic clear_strobes();
    io_wr_i  = 1'b0;
    io_rd_i  = 1'b0;
    mem_rd_i = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      clear_strobes();
    end
  endtask

  task automatic io_write(input logic [7:0] v);
    @(negedge clk);
    clear_strobes();
    io_wr_i    = 1'b1;
    io_wdata_i = v;
  endtask

  task automatic io_read(input logic [7:0] exp, input string req);
    @(negedge clk);
    clear_strobes();
    io_rd_i = 1'b1;
    @(negedge clk);
    clear_strobes();
    check(io_rdata_o == exp, req, io_rdata_o, exp);
  endtask

  // Driver: issues a read, checks the claim and address now, queues the data
  task automatic mem_read(input logic [ADDR_W-1:0] a, input bit exp_claim,
                          input int bank, input string req);
    logic [ROM_AW-1:0] ea;
    @(negedge clk);
    clear_strobes();
    mem_rd_i   = 1'b1;
    mem_addr_i = a;
    #1;
    check(mem_claim_o == exp_claim, {req, " claim"}, mem_claim_o, exp_claim);
    ea = ROM_AW'(((bank * 32'h10000) % (1 << ROM_AW)) + a[15:0]);
    if (exp_claim) begin
      check(rom_addr_o == ea, {req, " R4 rom address"}, rom_addr_o, ea);
      exp_q.push_back(rom_byte(ea));
    end else begin
      exp_q.push_back(8'hFF);
    end
    tag_q.push_back(req);
  endtask

  // Monitor: pops one expected byte per valid result
  always @(negedge clk) begin
    if (!rst && mem_rvalid_o) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R6 unexpected rvalid", mem_rdata_o, 0);
      end else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(mem_rdata_o == e, {t, " R6 data"}, mem_rdata_o, e);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // Reset with ROM fitted
    repeat (3) @(negedge clk);
    rst = 1'b0;
    io_read(8'h00, "R1 reset readback");
    mem_read(20'hA1234, 1'b0, 0, "R1 closed after reset");
    mem_read(20'h01234, 1'b0, 0, "R10 outside window");

    // Open bank 1; read the very next cycle
    io_write(8'h81);
    mem_read(20'hA0000, 1'b1, 1, "R9 immediate R3 low edge");
    mem_read(20'hAFFFF, 1'b1, 1, "R3 high edge");
    mem_read(20'hA5A5A, 1'b1, 1, "R6 back-to-back");
    mem_read(20'h9FFFF, 1'b0, 1, "R3 below window");
    mem_read(20'hB0000, 1'b0, 1, "R3 above window");
    io_read(8'h81, "R2 readback 0x81");

    // Wrap: bank 5 -> 1, bank 127 -> 3 on a four-bank image
    io_write(8'h85);
    mem_read(20'hA0042, 1'b1, 1, "R5 bank 5 wraps");
    io_write(8'hFF);
    mem_read(20'hA7700, 1'b1, 3, "R5 bank 127 wraps");
    io_read(8'hFF, "R2 readback 0xFF");
    io_write(8'h82);
    mem_read(20'hA0100, 1'b1, 2, "R9 switch bank 2");

    // Disable: bank bits kept, window closed
    io_write(8'h05);
    mem_read(20'hA0100, 1'b0, 5, "R3 enable clear");
    io_read(8'h05, "R2 readback 0x05");

    // Fitted pin dropped without reset: still claims
    io_write(8'h80);
    rom_fitted_i = 1'b0;
    mem_read(20'hA0010, 1'b1, 0, "R8 pin change ignored");
    idle(3);

    // Reset with no ROM
    rst = 1'b1;
    idle(3);
    rst = 1'b0;
    io_read(8'h00, "R1 reset clears register");
    io_write(8'h81);
    mem_read(20'hA0010, 1'b0, 1, "R7 no ROM");
    rom_fitted_i = 1'b1;
    mem_read(20'hA0020, 1'b0, 1, "R8 pin rise ignored");
    io_read(8'h81, "R2 readback no ROM");
    idle(3);

    check(exp_q.size() == 0, "R6 results drained", exp_q.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule